// File: doc/BRIEF.md
# Byte Output Port with Interrupt Vector

This block is a byte-wide output peripheral that sits on a simple processor bus. Software sees three byte registers at fixed offsets from a base address: a data register, a status register and a vector register. A byte written to the data register is held and offered to a slower downstream device over a valid/ready handshake. Until that device takes the byte, the port reports itself busy.

Software can poll the status register for readiness and for a sticky overrun error, or it can set an enable bit so that the port requests service whenever it can accept another byte. When the processor acknowledges that request, the port places the programmed vector number on the read data bus. The processor can then branch to the matching handler.

Top module: `mmio_out_port`

## Requirements
- R1: After reset the port is ready, interrupts are disabled, the error flag is clear, the vector register holds 0x00, `irq` is low and `dev_valid` is low.
- R2: A write to offset 1 while the port is ready makes `dev_valid` high with `dev_data` equal to the written byte from the next clock edge onward, and the ready flag reads 0.
- R3: While `dev_valid` is high and `dev_ready` is low, `dev_valid` and `dev_data` hold. A clock edge with both high ends the transfer: `dev_valid` falls and the ready flag reads 1.
- R4: A write to offset 1 while the port is busy drops the byte, so `dev_data` is unchanged, and sets the error flag.
- R5: Writing a status byte with bit 0 set clears the error flag. Writing bit 0 as 0 leaves the flag as it is.
- R6: Status bit 2 is the interrupt enable and can be read and written. `irq` is active-high and equals ready AND enable; status bit 1 shows the same value.
- R7: While `int_ack` is high, `bus_rdata` carries the vector register contents, whatever read is in progress.
- R8: Accesses outside offsets 1, 3 and 5, or made with `bus_sel` low, change no state, and reads at such addresses return 0x00.
- R9: The status byte (offset 3) reads with bit 7 = ready, bit 2 = enable, bit 1 = request, bit 0 = error, and all other bits 0.
- R10: The vector register (offset 5) reads back the last byte written to it and changes only when written. The data register (offset 1) reads back the byte held for the device.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus cycle is addressed to peripherals |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data or vector during acknowledge |
| int_ack | input | 1 | Interrupt acknowledge from the processor |
| irq | output | 1 | Active-high service request |
| dev_valid | output | 1 | Byte offered to downstream device |
| dev_data | output | 8 | Byte offered to downstream device |
| dev_ready | input | 1 | Downstream device accepts the byte |

## Verification
The hardest state to reach is an overrun: a byte is still pending, and a second data write arrives while the error flag, the enable bit and the request line all have to be observed together. The stimulus holds `dev_ready` low through a run of table-driven register accesses. This keeps the port busy while a second byte is written and the error flag is cleared and left alone in turn. The handshake is then released and the request line and the acknowledge vector are checked.

// File: rtl/mmo_pkg.sv
package mmo_pkg;
  localparam int BYTE_W   = 8;
  localparam int OFF_DATA = 1;
  localparam int OFF_STAT = 3;
  localparam int OFF_VEC  = 5;
  localparam int BIT_RDY  = 7;
  localparam int BIT_EN   = 2;
  localparam int BIT_INT  = 1;
  localparam int BIT_ERR  = 0;

  typedef enum logic [1:0] {SEL_NONE, SEL_DATA, SEL_STAT, SEL_VEC} regsel_e;

  function automatic logic [BYTE_W-1:0] pack_status(input logic rdy, input logic en,
                                                    input logic req, input logic err);
    logic [BYTE_W-1:0] s;
    s          = '0;
    s[BIT_RDY] = rdy;
    s[BIT_EN]  = en;
    s[BIT_INT] = req;
    s[BIT_ERR] = err;
    return s;
  endfunction
endpackage

// File: rtl/mmo_decode.sv
module mmo_decode
  import mmo_pkg::*;
#(
  parameter int          ADDR_W = 16,
  parameter int unsigned BASE   = 32'h8000
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  output regsel_e           wsel,
  output regsel_e           rsel
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(BASE + OFF_DATA);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(BASE + OFF_STAT);
  localparam logic [ADDR_W-1:0] A_VEC  = ADDR_W'(BASE + OFF_VEC);

  function automatic regsel_e lookup(input logic [ADDR_W-1:0] a);
    if (a == A_DATA)      return SEL_DATA;
    else if (a == A_STAT) return SEL_STAT;
    else if (a == A_VEC)  return SEL_VEC;
    else                  return SEL_NONE;
  endfunction

  regsel_e hit;
  always_comb begin
    hit  = lookup(bus_addr);
    wsel = (bus_sel && bus_wr) ? hit : SEL_NONE;
    rsel = (bus_sel && bus_rd) ? hit : SEL_NONE;
  end
endmodule

// File: rtl/mmo_txbuf.sv
module mmo_txbuf #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_data,
  input  logic [W-1:0] wdata,
  input  logic         dev_ready,
  output logic         dev_valid,
  output logic [W-1:0] dev_data,
  output logic         rdy,
  output logic         overrun,
  output logic         hs_done
);
  logic         full_q;
  logic [W-1:0] hold_q;
  logic         accept;

  assign accept    = wr_data && !full_q;
  assign overrun   = wr_data && full_q;
  assign hs_done   = full_q && dev_ready;
  assign rdy       = !full_q;
  assign dev_valid = full_q;
  assign dev_data  = hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      hold_q <= '0;
    end else begin
      if (accept) begin
        full_q <= 1'b1;
        hold_q <= wdata;
      end else if (hs_done) begin
        full_q <= 1'b0;
      end
    end
  end

  // R3: offered byte held until taken
  p_valid_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_valid && !dev_ready) |=> (dev_valid && $stable(dev_data)));
  // R3: completed handshake frees the port
  p_rdy_after_hs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hs_done |=> rdy);
  // R4: dropped byte leaves held byte untouched
  p_drop_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> $stable(dev_data));
endmodule

// File: rtl/mmo_ctrl.sv
module mmo_ctrl
  import mmo_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stat,
  input  logic              wr_vec,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              overrun,
  input  logic              rdy,
  output logic              en,
  output logic              err,
  output logic              req,
  output logic [BYTE_W-1:0] vec
);
  logic              en_q;
  logic              err_q;
  logic [BYTE_W-1:0] vec_q;
  logic              err_clr;

  assign err_clr = wr_stat && wdata[BIT_ERR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      err_q <= 1'b0;
      vec_q <= '0;
    end else begin
      if (wr_stat) en_q <= wdata[BIT_EN];
      if (overrun)      err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
      if (wr_vec) vec_q <= wdata;
    end
  end

  assign en  = en_q;
  assign err = err_q;
  assign vec = vec_q;
  assign req = rdy && en_q;

  // R4: overrun is sticky
  p_err_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> err);
  // R5: clear request with no overrun empties flag
  p_err_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !overrun) |=> !err);
  // R6: request never without enable
  p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> en);
  // R10: vector changes only on its own write
  p_vec_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_vec |=> $stable(vec));
endmodule

// File: rtl/mmio_out_port.sv
module mmio_out_port
  import mmo_pkg::*;
#(
  parameter int          ADDR_W = 16,
  parameter int unsigned BASE   = 32'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              int_ack,
  output logic              irq,
  output logic              dev_valid,
  output logic [7:0]        dev_data,
  input  logic              dev_ready
);
  regsel_e           wsel, rsel;
  logic              wr_data, wr_stat, wr_vec;
  logic              rdy, overrun, hs_done;
  logic              en, err, req;
  logic [BYTE_W-1:0] vec;

  mmo_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .wsel(wsel), .rsel(rsel)
  );

  assign wr_data = (wsel == SEL_DATA);
  assign wr_stat = (wsel == SEL_STAT);
  assign wr_vec  = (wsel == SEL_VEC);

  mmo_txbuf #(.W(BYTE_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wdata(bus_wdata),
    .dev_ready(dev_ready), .dev_valid(dev_valid), .dev_data(dev_data),
    .rdy(rdy), .overrun(overrun), .hs_done(hs_done)
  );

  mmo_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_stat(wr_stat), .wr_vec(wr_vec),
    .wdata(bus_wdata), .overrun(overrun), .rdy(rdy),
    .en(en), .err(err), .req(req), .vec(vec)
  );

  assign irq = req;

  always_comb begin
    if (int_ack) bus_rdata = vec;
    else begin
      unique case (rsel)
        SEL_DATA: bus_rdata = dev_data;
        SEL_STAT: bus_rdata = pack_status(rdy, en, req, err);
        SEL_VEC:  bus_rdata = vec;
        default:  bus_rdata = '0;
      endcase
    end
  end

  // R6: request line follows readiness once enabled
  p_irq_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_done && en && !wr_stat) |=> irq);
  // R2: accepted byte is offered next cycle
  p_offer_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && !dev_valid) |=> (dev_valid && dev_data == $past(bus_wdata)));
endmodule

// File: tb/mmio_out_port_bench.sv
module mmio_out_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam logic [AW-1:0] BASE = 16'h8000;

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0, bus_rd = 0, int_ack = 0, dev_ready = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata, dev_data;
  logic irq, dev_valid;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mmio_out_port #(.ADDR_W(AW), .BASE(32'h8000)) u_mmio_out_port (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .int_ack(int_ack), .irq(irq), .dev_valid(dev_valid), .dev_data(dev_data),
    .dev_ready(dev_ready)
  );

  // entry: {is_write, offset[3:0], data[7:0], expected[7:0], req_no[7:0]}
  localparam int NV = 20;
  localparam logic [28:0] VEC [NV] = '{
    {1'b0, 4'd3, 8'h00, 8'h80, 8'd9},  // R9 status after reset
    {1'b0, 4'd5, 8'h00, 8'h00, 8'd1},  // R1 vector cleared
    {1'b1, 4'd5, 8'h5A, 8'h00, 8'd10},
    {1'b0, 4'd5, 8'h00, 8'h5A, 8'd10}, // R10 vector readback
    {1'b1, 4'd3, 8'h04, 8'h00, 8'd6},
    {1'b0, 4'd3, 8'h00, 8'h86, 8'd6},  // R6 enable + request
    {1'b1, 4'd1, 8'h3C, 8'h00, 8'd2},
    {1'b0, 4'd3, 8'h00, 8'h04, 8'd2},  // R2 busy, request drops
    {1'b0, 4'd1, 8'h00, 8'h3C, 8'd10}, // R10 data readback
    {1'b1, 4'd1, 8'h77, 8'h00, 8'd4},
    {1'b0, 4'd3, 8'h00, 8'h05, 8'd4},  // R4 error set
    {1'b0, 4'd1, 8'h00, 8'h3C, 8'd4},  // R4 byte dropped
    {1'b1, 4'd3, 8'h04, 8'h00, 8'd5},
    {1'b0, 4'd3, 8'h00, 8'h05, 8'd5},  // R5 bit0=0 keeps error
    {1'b1, 4'd3, 8'h05, 8'h00, 8'd5},
    {1'b0, 4'd3, 8'h00, 8'h04, 8'd5},  // R5 cleared
    {1'b1, 4'd2, 8'hFF, 8'h00, 8'd8},
    {1'b0, 4'd2, 8'h00, 8'h00, 8'd8},  // R8 hole reads zero
    {1'b0, 4'd3, 8'h00, 8'h04, 8'd8},  // R8 no state change
    {1'b0, 4'd5, 8'h00, 8'h5A, 8'd8}   // R8 vector untouched
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic [AW-1:0] a, input logic [7:0] d, input logic sel);
    @(negedge clk);
    bus_sel = sel; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bread(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0; bus_rd = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check("R1 irq", {7'd0, irq}, 8'h00);
    check("R1 dev_valid", {7'd0, dev_valid}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][28]) bwrite(BASE + 16'(VEC[i][27:24]), VEC[i][23:16], 1'b1);
      else begin
        bread(BASE + 16'(VEC[i][27:24]), rd);
        check($sformatf("R%0d vec%0d", VEC[i][7:0], i), rd, VEC[i][15:8]);
      end
    end

    // R3: held while not ready
    #1 check("R3 valid hold", {7'd0, dev_valid}, 8'h01);
    check("R3 data hold", dev_data, 8'h3C);
    check("R6 irq low busy", {7'd0, irq}, 8'h00);
    @(negedge clk); dev_ready = 1;
    @(negedge clk); dev_ready = 0;
    #1 check("R3 valid dropped", {7'd0, dev_valid}, 8'h00);
    check("R6 irq raised", {7'd0, irq}, 8'h01);
    bread(BASE + 3, rd);
    check("R3 R9 ready status", rd, 8'h86);

    // R7: acknowledge overrides a status read
    @(negedge clk);
    int_ack = 1; bus_sel = 1; bus_rd = 1; bus_addr = BASE + 3;
    #1 check("R7 ack vector", bus_rdata, 8'h5A);
    @(negedge clk); int_ack = 0; bus_sel = 0; bus_rd = 0;

    // R2: fresh byte offered
    bwrite(BASE + 1, 8'h91, 1'b1);
    #1 check("R2 valid", {7'd0, dev_valid}, 8'h01);
    check("R2 data", dev_data, 8'h91);
    check("R6 irq busy", {7'd0, irq}, 8'h00);
    @(negedge clk); dev_ready = 1;
    @(negedge clk); dev_ready = 0;

    // R8: unselected and off-map writes ignored
    bwrite(BASE + 1, 8'hEE, 1'b0);
    bwrite(BASE + 16'h11, 8'hEE, 1'b1);
    #1 check("R8 no offer", {7'd0, dev_valid}, 8'h00);
    bwrite(BASE + 3, 8'h00, 1'b0);
    #1 check("R8 irq kept", {7'd0, irq}, 8'h01);

    // R6: disable drops request
    bwrite(BASE + 3, 8'h00, 1'b1);
    #1 check("R6 irq off", {7'd0, irq}, 8'h00);

    // R1: reset mid-run
    bwrite(BASE + 1, 8'h42, 1'b1);
    bwrite(BASE + 1, 8'h43, 1'b1);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    bread(BASE + 3, rd); check("R1 status", rd, 8'h80);
    bread(BASE + 5, rd); check("R1 vector", rd, 8'h00);
    check("R1 dev_valid", {7'd0, dev_valid}, 8'h00);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule